// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Loader

This block sits in front of a nonvolatile array and gathers single-byte writes into a page latch of 128 entries. Each entry has its own valid flag. It then hands the whole page to the array as one programming request. The first accepted write opens a load window and fixes the target page. Further bytes for that page may arrive in any order, and a byte may be rewritten. The window closes when no byte has arrived for a set number of microsecond ticks.

When the window closes, the block issues a one-cycle request. The request carries the page number, the latched bytes and a mask. The mask marks only the offsets that were written, so the array programs those bytes and leaves the rest of the page as it was. The block then stays busy for the whole programming time and clears the mask at the end.

After reset, writes are locked out for a power-on delay. A write is only taken when the strobe comes with the chip selected, the output drive off and the write enable active.

Top module: `page_write_loader`

## Requirements
- R1: After reset, `busy` is high and every write is ignored until POR_US microsecond ticks have been counted. At that point `busy` falls.
- R2: A write is accepted only in a cycle where `wr_stb`=1, `chip_en_n`=0, `out_en_n`=1 and `wr_en_n`=0. A strobe with any other combination changes neither the mask nor the data.
- R3: `addr[6:0]` selects the byte within the page. `addr[16:7]` is the page number. It is captured by the first accepted write of a window and shown on `prog_page`.
- R4: Inside an open window, an accepted write whose `addr[16:7]` differs from the captured page is dropped. It raises `page_err` for exactly the following cycle and does not restart the inactivity count.
- R5: Bytes may be written in any order. A second write to the same offset replaces the stored byte; the last value written wins.
- R6: The window closes once WIN_US ticks pass with no accepted same-page write. `prog_req` is then high for one cycle, and `busy` rises in that same cycle.
- R7: `page_mask` bit i is set only for offsets written in the current window. Byte i of `page_data` (bits 8i+7:8i) holds the value written there.
- R8: `busy` stays high for PROG_US ticks after the request, and writes are ignored during that time. At the end, `page_mask` returns to zero and `busy` falls together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| wr_stb | input | 1 | Synchronous write strobe |
| chip_en_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Output drive enable, active low (must be high to write) |
| wr_en_n | input | 1 | Write enable, active low |
| addr | input | 17 | Byte address: page in 16:7, offset in 6:0 |
| wdata | input | 8 | Write byte |
| prog_req | output | 1 | One-cycle programming request |
| prog_page | output | 10 | Captured page number |
| page_data | output | 1024 | Latched bytes, byte i at bits 8i+7:8i |
| page_mask | output | 128 | Per-byte valid flags |
| busy | output | 1 | Lockout or programming in progress |
| page_err | output | 1 | One-cycle pulse for a dropped cross-page write |

## Verification
Suppose the inactivity count is wrong by a single tick. The programming request and the rise of `busy` then move by one cycle, and a per-cycle comparison shows this at once. A valid flag that is set wrongly or not cleared shows up on `page_mask` in the cycle after the write or after the end of programming. A gating or page-match error changes the mask or the error pulse in the very next cycle, long before any request goes out.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
  typedef enum logic [1:0] {
    ST_LOCK = 2'd0,
    ST_IDLE = 2'd1,
    ST_LOAD = 2'd2,
    ST_PROG = 2'd3
  } pwl_state_e;

  // true when a tick counter sits on the final count of a limit
  function automatic logic at_limit(input int unsigned cnt, input int unsigned lim);
    return cnt == lim - 1;
  endfunction

  // widest of three counts
  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/pwl_gate.sv
module pwl_gate (
  input  logic wr_stb,
  input  logic chip_en_n,
  input  logic out_en_n,
  input  logic wr_en_n,
  output logic wr_ok
);
  assign wr_ok = wr_stb & ~chip_en_n & out_en_n & ~wr_en_n;
endmodule

// File: rtl/pwl_latch.sv
module pwl_latch #(
  parameter int OFS_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_en,
  input  logic [OFS_W-1:0]              ofs,
  input  logic [DATA_W-1:0]             wdata,
  input  logic                          clr,
  output logic [(1<<OFS_W)*DATA_W-1:0]  data_flat,
  output logic [(1<<OFS_W)-1:0]         mask
);
  localparam int ENTRIES = 1 << OFS_W;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic hit;
    assign hit = load_en && (ofs == OFS_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_flat[i*DATA_W +: DATA_W] <= '0;
        mask[i]                       <= 1'b0;
      end else if (hit) begin
        data_flat[i*DATA_W +: DATA_W] <= wdata;
        mask[i]                       <= 1'b1;
      end else if (clr) begin
        mask[i]                       <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwl_seq.sv
module pwl_seq
  import pwl_pkg::*;
#(
  parameter int POR_US  = 5000,
  parameter int WIN_US  = 150,
  parameter int PROG_US = 10000,
  parameter int CNT_W   = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       wr_ok,
  input  logic       page_hit,
  output pwl_state_e state,
  output logic       load_en,
  output logic       page_cap,
  output logic       err_pulse,
  output logic       prog_pulse,
  output logic       por_done,
  output logic       win_close,
  output logic       prog_done
);
  logic [CNT_W-1:0] cnt;
  logic             bad_page;

  assign load_en   = wr_ok & ((state == ST_IDLE) | ((state == ST_LOAD) & page_hit));
  assign page_cap  = wr_ok & (state == ST_IDLE);
  assign bad_page  = wr_ok & (state == ST_LOAD) & ~page_hit;
  assign por_done  = (state == ST_LOCK) & us_tick & at_limit(32'(cnt), POR_US);
  assign win_close = (state == ST_LOAD) & ~load_en & us_tick & at_limit(32'(cnt), WIN_US);
  assign prog_done = (state == ST_PROG) & us_tick & at_limit(32'(cnt), PROG_US);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_LOCK;
      cnt        <= '0;
      err_pulse  <= 1'b0;
      prog_pulse <= 1'b0;
    end else begin
      err_pulse  <= bad_page;
      prog_pulse <= win_close;
      unique case (state)
        ST_LOCK: begin
          if (por_done) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else if (us_tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_IDLE: begin
          if (load_en) begin
            state <= ST_LOAD;
            cnt   <= '0;
          end
        end
        ST_LOAD: begin
          if (load_en) begin
            cnt <= '0;
          end else if (win_close) begin
            state <= ST_PROG;
            cnt   <= '0;
          end else if (us_tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PROG: begin
          if (prog_done) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else if (us_tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_LOCK;
      endcase
    end
  end
endmodule

// File: rtl/page_write_loader.sv
module page_write_loader
  import pwl_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int OFS_W   = 7,
  parameter int DATA_W  = 8,
  parameter int POR_US  = 5000,
  parameter int WIN_US  = 150,
  parameter int PROG_US = 10000
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  us_tick,
  input  logic                                  wr_stb,
  input  logic                                  chip_en_n,
  input  logic                                  out_en_n,
  input  logic                                  wr_en_n,
  input  logic [ADDR_W-1:0]                     addr,
  input  logic [DATA_W-1:0]                     wdata,
  output logic                                  prog_req,
  output logic [ADDR_W-OFS_W-1:0]               prog_page,
  output logic [(1<<OFS_W)*DATA_W-1:0]          page_data,
  output logic [(1<<OFS_W)-1:0]                 page_mask,
  output logic                                  busy,
  output logic                                  page_err
);
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int CNT_W  = $clog2(max3(POR_US, WIN_US, PROG_US) + 1);

  pwl_state_e        state;
  logic              wr_ok, page_hit, load_en, page_cap;
  logic              por_done, win_close, prog_done;
  logic [PAGE_W-1:0] page_q;

  pwl_gate u_gate (
    .wr_stb(wr_stb), .chip_en_n(chip_en_n), .out_en_n(out_en_n),
    .wr_en_n(wr_en_n), .wr_ok(wr_ok)
  );

  assign page_hit = (addr[ADDR_W-1:OFS_W] == page_q);

  pwl_seq #(.POR_US(POR_US), .WIN_US(WIN_US), .PROG_US(PROG_US), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .wr_ok(wr_ok), .page_hit(page_hit),
    .state(state), .load_en(load_en), .page_cap(page_cap), .err_pulse(page_err),
    .prog_pulse(prog_req), .por_done(por_done), .win_close(win_close),
    .prog_done(prog_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        page_q <= '0;
    else if (page_cap) page_q <= addr[ADDR_W-1:OFS_W];
  end

  pwl_latch #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .ofs(addr[OFS_W-1:0]),
    .wdata(wdata), .clr(prog_done), .data_flat(page_data), .mask(page_mask)
  );

  assign prog_page = page_q;
  assign busy      = (state == ST_LOCK) | (state == ST_PROG);
endmodule

// File: rtl/pwl_chk.sv
module pwl_chk
  import pwl_pkg::*;
#(
  parameter int MASK_W = 128,
  parameter int PAGE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_ok,
  input logic              prog_req,
  input logic              page_err,
  input logic              busy,
  input logic              prog_done,
  input logic [MASK_W-1:0] page_mask,
  input logic [PAGE_W-1:0] prog_page,
  input pwl_state_e        state
);
  // R2: no accepted write, no programming end -> flags unchanged
  p_gate_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ok && !prog_done) |=> $stable(page_mask));

  // R3: page number frozen while loading
  p_page_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD) |=> $stable(prog_page));

  // R4: dropped cross-page write leaves flags untouched
  p_err_nomask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |-> $stable(page_mask));

  // R6: request is a single cycle and coincides with busy
  p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);
  p_req_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> busy);

  // R8: programming end clears flags and releases busy
  p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> (page_mask == '0) && !busy);

  // R1, R8: no flag may change while busy and not finishing
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prog_done) |=> $stable(page_mask));
endmodule

bind page_write_loader pwl_chk #(.MASK_W(1 << OFS_W), .PAGE_W(ADDR_W - OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .prog_req(prog_req), .page_err(page_err),
  .busy(busy), .prog_done(prog_done), .page_mask(page_mask), .prog_page(prog_page),
  .state(state)
);

// File: tb/tb_page_write_loader.sv
`timescale 1ns/1ps
module tb_page_write_loader;
  localparam int POR  = 5000;
  localparam int WIN  = 150;
  localparam int PROG = 10000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         us_tick = 1'b0;
  logic         wr_stb = 1'b0, chip_en_n = 1'b1, out_en_n = 1'b1, wr_en_n = 1'b1;
  logic [16:0]  addr = '0;
  logic [7:0]   wdata = '0;
  logic         prog_req, busy, page_err;
  logic [9:0]   prog_page;
  logic [1023:0] page_data;
  logic [127:0] page_mask;

  int checks = 0, fails = 0, req_seen = 0, cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  page_write_loader dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .wr_stb(wr_stb),
    .chip_en_n(chip_en_n), .out_en_n(out_en_n), .wr_en_n(wr_en_n),
    .addr(addr), .wdata(wdata), .prog_req(prog_req), .prog_page(prog_page),
    .page_data(page_data), .page_mask(page_mask), .busy(busy), .page_err(page_err)
  );

  // ---------------- behavioural reference ----------------
  int  m_st = 0;        // 0 lockout, 1 idle, 2 loading, 3 programming
  int  m_cnt = 0;
  int  m_page = 0;
  bit  m_req = 0, m_err = 0;
  bit  m_mask[128];
  byte m_data[128];

  always @(posedge clk) begin
    bit acc;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_req = 0; m_err = 0;
      foreach (m_mask[i]) m_mask[i] = 0;
    end else begin
      acc = wr_stb && !chip_en_n && out_en_n && !wr_en_n;
      m_req = 0; m_err = 0;
      case (m_st)
        0: if (us_tick) begin
             if (m_cnt == POR - 1) begin m_st = 1; m_cnt = 0; end else m_cnt++;
           end
        1: if (acc) begin
             m_st = 2; m_cnt = 0; m_page = int'(addr >> 7);
             m_mask[addr % 128] = 1; m_data[addr % 128] = wdata;
           end
        2: if (acc && int'(addr >> 7) == m_page) begin
             m_mask[addr % 128] = 1; m_data[addr % 128] = wdata; m_cnt = 0;
           end else begin
             if (acc) m_err = 1;
             if (us_tick) begin
               if (m_cnt == WIN - 1) begin m_st = 3; m_cnt = 0; m_req = 1; end
               else m_cnt++;
             end
           end
        default: if (us_tick) begin
             if (m_cnt == PROG - 1) begin
               m_st = 1; m_cnt = 0;
               foreach (m_mask[i]) m_mask[i] = 0;
             end else m_cnt++;
           end
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !finished) begin
      logic [127:0] em;
      bit bexp;
      bexp = (m_st == 0) || (m_st == 3);
      check(busy == bexp, (m_st == 0) ? "R1" : "R8", "busy", busy, bexp);
      check(prog_req == m_req, "R6", "prog_req", prog_req, m_req);
      check(page_err == m_err, "R4", "page_err", page_err, m_err);
      if (m_req) check(prog_page == 10'(m_page), "R3", "prog_page", prog_page, m_page);
      for (int i = 0; i < 128; i++) em[i] = m_mask[i];
      check(page_mask == em, "R7", "page_mask", 0, 0);
      if (page_mask != em)
        $display("  mask actual %h expected %h", page_mask, em);
      for (int i = 0; i < 128; i++)
        if (m_mask[i] && page_mask[i] && page_data[i*8 +: 8] != 8'(m_data[i]))
          check(0, "R5", $sformatf("byte %0d", i), page_data[i*8 +: 8], m_data[i]);
      if (prog_req) req_seen++;
    end
  end

  // tick: high three cycles of every four
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      us_tick = (k % 4) != 3;
      k++;
    end
  end

  task automatic wr(input int a, input int d, input bit ce_n = 0, input bit oe_n = 1,
                    input bit we_n = 0);
    @(negedge clk);
    wr_stb = 1; addr = 17'(a); wdata = 8'(d);
    chip_en_n = ce_n; out_en_n = oe_n; wr_en_n = we_n;
    @(negedge clk);
    wr_stb = 0; chip_en_n = 1; wr_en_n = 1; out_en_n = 1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ready;
    while (busy) @(negedge clk);
    idle(2);
  endtask

  task automatic finish_run;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 1, "R1", "reset busy", busy, 1);
    check(page_mask == '0, "R1", "reset mask", 0, 0);
    check(prog_req == 0, "R1", "reset prog_req", prog_req, 0);
    rst_n = 1;
    idle(10);
    // R1: write during lockout ignored
    wr(17'h00005, 8'h11);
    idle(2);
    check(page_mask == '0, "R1", "lockout write mask", 0, 0);
    wait_ready();

    // R3 R5 R7: out-of-order loads with an overwrite, page 0x155
    base = 10'h155 << 7;
    wr(base + 5, 8'hA5);
    wr(base + 3, 8'h33);
    wr(base + 127, 8'hF7);
    wr(base + 0, 8'h01);
    wr(base + 3, 8'h3C);  // R5 overwrite
    // R2: inhibited strobes to offset 9
    wr(base + 9, 8'h99, 1, 1, 0);
    wr(base + 9, 8'h99, 0, 0, 0);
    wr(base + 9, 8'h99, 0, 1, 1);
    idle(2);
    check(page_mask[9] == 0, "R2", "inhibited offset 9", page_mask[9], 0);
    check(page_data[3*8 +: 8] == 8'h3C, "R5", "overwrite", page_data[3*8 +: 8], 8'h3C);
    // R4: cross-page write dropped
    wr(base + 128 + 9, 8'hEE);
    idle(2);
    check(page_mask[9] == 0, "R4", "cross-page offset 9", page_mask[9], 0);
    // R6: window closes, request follows
    while (!prog_req) @(negedge clk);
    check(prog_page == 10'h155, "R3", "page at request", prog_page, 10'h155);
    check($countones(page_mask) == 4, "R7", "mask count", $countones(page_mask), 4);
    // R8: write during programming ignored
    wr(base + 20, 8'h20);
    idle(2);
    check(page_mask[20] == 0, "R8", "write while programming", page_mask[20], 0);
    wait_ready();
    check(page_mask == '0, "R8", "mask cleared", 0, 0);

    // R6: writes spaced just inside the window keep it open
    base = 10'h3FF << 7;
    wr(base + 127, 8'h5A);
    for (int i = 0; i < 4; i++) begin
      idle(150);  // ~112 ticks
      check(prog_req == 0 && !busy, "R6", "window still open", prog_req, 0);
      wr(base + i, 8'(8'hC0 + i));
    end
    while (!prog_req) @(negedge clk);
    check($countones(page_mask) == 5, "R7", "spaced mask count", $countones(page_mask), 5);
    wait_ready();

    // single-byte page
    wr(17'h00080, 8'h77);
    while (!prog_req) @(negedge clk);
    check(prog_page == 10'h001 && page_mask == 128'h1, "R7", "single byte", page_mask, 1);
    wait_ready();
    check(req_seen == 3, "R6", "request count", req_seen, 3);
    finish_run();
  end
endmodule